// File: doc/BRIEF.md
# SPI Master/Slave Shift Engine

This block moves words between a host and a synchronous four-wire serial link. It works either as the clock-owning master or as a slave that follows a remote clock and select line. On the host side there is one transmit holding register and one receive holding register, one word deep each, and three level interrupt requests: transmit holding empty, receive holding full, and receive overrun.

As master, the engine starts a frame on its own as soon as the transmit register holds a word and no frame is running. The word length is 8 or 9 bits. The serial clock runs either at half the core clock (fast timing) or at a rate set by counting pulses of an external tick (normal timing). As slave, the frame length is always 8 bits. The remote clock, select and data inputs pass through a synchronizer. Clock polarity, clock phase and bit order can be chosen in both roles.

Top module: `spi_xfer_engine`

## Requirements
- R1: After reset `irq_tx_empty` is 1, `irq_rx_full` is 0, `irq_rx_err` is 0 and `busy` is 0. From the first clock on, a master that is not running holds `sck_o` at `cfg_cpol`.
- R2: In master mode (`cfg_slave`=0) a word written with `tx_wr` while no frame runs starts a frame by itself. Loading the word into the shifter sets `irq_tx_empty` to 1. A frame is exactly 16 `sck_o` edges when `cfg_nine`=0 and 18 edges when `cfg_nine`=1. After the frame `busy` returns to 0.
- R3: `sck_o` rests at `cfg_cpol`. The leading edge is the first edge of each bit. With `cfg_cpha`=0 the first bit is on `sdo` before the first leading edge, data is sampled on leading edges and changes on trailing edges. With `cfg_cpha`=1 data changes on leading edges and is sampled on trailing edges.
- R4: With `cfg_lsb_first`=1, bit 0 goes out and comes in first. Otherwise the top bit of the frame goes first: bit 8 for 9-bit frames, bit 7 for 8-bit frames. Received words appear right-aligned in `rx_data` with unused upper bits 0.
- R5: With `cfg_fast`=1 every `sck_o` half period lasts one core clock. With `cfg_fast`=0 a half period lasts `cfg_div`+1 core cycles on which `div_tick` is high.
- R6: A completed frame stores the received word in `rx_data` and sets `irq_rx_full`. `rx_rd` clears `irq_rx_full`. While `irq_rx_full` is 1 and `rx_rd` is 0, `rx_data` does not change.
- R7: If a frame completes while `irq_rx_full` is 1 and `rx_rd` is 0, `irq_rx_err` is set and `rx_data` keeps the unread word. `rx_rd` clears `irq_rx_err`.
- R8: In slave mode the frame is 8 bits whatever `cfg_nine` holds. Bits are shifted on edges of `sck_i` while `cs_n_i` is low. The byte to send is taken from the transmit register when `cs_n_i` falls and again after each completed frame.
- R9: In slave mode, if `cs_n_i` rises in the middle of a frame, the frame is dropped. `irq_rx_full` and `rx_data` are not updated, and the next selection starts again from the first bit.
- R10: `tx_wr` makes `irq_tx_empty` 0 on the next cycle, even if a load happens in the same cycle.
- R11: `sdo_oe` is 1 in master mode. In slave mode it is 1 only while `cs_n_i` (after the synchronizer) is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_slave | input | 1 | 1 selects slave role, 0 master |
| cfg_cpol | input | 1 | Serial clock rest level |
| cfg_cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| cfg_lsb_first | input | 1 | 1 shifts bit 0 first |
| cfg_nine | input | 1 | Master only: 1 selects 9-bit frames |
| cfg_fast | input | 1 | Master only: 1 runs the clock at half the core clock |
| cfg_div | input | DIV_W | Normal timing: half period is cfg_div+1 tick pulses |
| div_tick | input | 1 | Divided timebase pulse for normal timing |
| tx_wr | input | 1 | Write strobe for the transmit register |
| tx_data | input | 9 | Word to transmit |
| rx_rd | input | 1 | Read acknowledge for the receive register |
| rx_data | output | 9 | Last received word |
| irq_tx_empty | output | 1 | Transmit register empty request |
| irq_rx_full | output | 1 | Receive register full request |
| irq_rx_err | output | 1 | Receive overrun request |
| busy | output | 1 | Master frame running, or slave selected |
| sck_o | output | 1 | Serial clock generated as master |
| sck_i | input | 1 | Serial clock from a remote master |
| cs_n_i | input | 1 | Active-low select from a remote master |
| sdi | input | 1 | Serial data in (remote output in either role) |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo |

## Verification
The hardest state to reach from the ports is a slave frame cut off part way. The synchronizer delays `cs_n_i` and `sck_i` by the same number of cycles, so the abort only counts if the bench releases select after a few real clock edges and then confirms that neither the receive flag nor the data moved. To get there, the bench acts as the remote master: it moves `sck_i` and `sdi` with a slow half period and raises select after three bits. It then runs a clean frame and checks that the received byte is not mixed with the aborted one. The overrun path needs two master frames with no read between them. The bench plays the remote slave on the master sweep and checks both directions of every frame across all polarity, phase, order, length and timing combinations.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  localparam int unsigned WORD_W = 9;
  typedef logic [WORD_W-1:0] word_t;

  // bit that leaves the shifter next
  function automatic logic head_bit(input word_t w, input logic lsb, input logic nine);
    logic b;
    if (lsb)       b = w[0];
    else if (nine) b = w[WORD_W-1];
    else           b = w[WORD_W-2];
    return b;
  endfunction

  function automatic word_t tx_step(input word_t w, input logic lsb);
    word_t r;
    if (lsb) r = w >> 1;
    else     r = w << 1;
    return r;
  endfunction

  function automatic word_t rx_step(input word_t w, input logic b, input logic lsb, input logic nine);
    word_t r;
    if (lsb) begin
      r = w >> 1;
      if (nine) r[WORD_W-1] = b;
      else begin
        r[WORD_W-1] = 1'b0;
        r[WORD_W-2] = b;
      end
    end else begin
      r = {w[WORD_W-2:0], b};
    end
    return r;
  endfunction

  function automatic word_t fit(input word_t w, input logic nine);
    word_t r;
    r = w;
    if (!nine) r[WORD_W-1] = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             fast_mode,
  input  logic [DIV_W-1:0] div_val,
  input  logic             tick,
  output logic             half
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    half  = 1'b0;
    if (!run) begin
      cnt_d = '0;
    end else if (fast_mode) begin
      half = 1'b1;
    end else if (tick) begin
      if (cnt_q >= div_val) begin
        half  = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  assign cnt_en = (cnt_d != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int unsigned   STAGES  = 2,
  parameter int unsigned   W       = 3,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  genvar g;
  for (g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] q;
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= g_stage[g-1].q;
      end
    end
  end

  assign dout = g_stage[STAGES-1].q;

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_eng_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  word_t            load_word,
  input  logic             cpha,
  input  logic             lsb_first,
  input  logic             nine,
  input  logic             launch,
  input  logic             sample,
  input  logic             clear,
  input  logic             sdi,
  output logic             sdo,
  output logic             done,
  output word_t            rx_word,
  output logic [CNT_W-1:0] bit_cnt
);

  localparam logic [CNT_W-1:0] LAST8 = CNT_W'(7);
  localparam logic [CNT_W-1:0] LAST9 = CNT_W'(8);

  word_t            tx_q, tx_d, rx_q, rx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             out_q, out_d;
  logic             upd;
  logic [CNT_W-1:0] last_idx;
  word_t            rx_shift;

  assign last_idx = nine ? LAST9 : LAST8;
  assign rx_shift = rx_step(rx_q, sdi, lsb_first, nine);
  assign done     = sample & (cnt_q == last_idx);
  assign rx_word  = fit(rx_shift, nine);
  assign upd      = load | clear | launch | sample;

  always_comb begin
    tx_d  = tx_q;
    rx_d  = rx_q;
    cnt_d = cnt_q;
    out_d = out_q;
    if (load) begin
      cnt_d = '0;
      rx_d  = '0;
      if (!cpha) begin
        out_d = head_bit(load_word, lsb_first, nine);
        tx_d  = tx_step(load_word, lsb_first);
      end else begin
        tx_d  = load_word;
      end
    end else if (clear) begin
      cnt_d = '0;
      rx_d  = '0;
    end else begin
      if (launch) begin
        out_d = head_bit(tx_q, lsb_first, nine);
        tx_d  = tx_step(tx_q, lsb_first);
      end
      if (sample) begin
        rx_d  = rx_shift;
        cnt_d = done ? '0 : cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      rx_q  <= '0;
      cnt_q <= '0;
      out_q <= 1'b0;
    end else if (upd) begin
      tx_q  <= tx_d;
      rx_q  <= rx_d;
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign sdo     = out_q;
  assign bit_cnt = cnt_q;

endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_eng_pkg::*;
#(
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_slave,
  input  logic             cfg_cpol,
  input  logic             cfg_cpha,
  input  logic             cfg_lsb_first,
  input  logic             cfg_nine,
  input  logic             cfg_fast,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             div_tick,
  input  logic             tx_wr,
  input  logic [8:0]       tx_data,
  input  logic             rx_rd,
  output logic [8:0]       rx_data,
  output logic             irq_tx_empty,
  output logic             irq_rx_full,
  output logic             irq_rx_err,
  output logic             busy,
  output logic             sck_o,
  input  logic             sck_i,
  input  logic             cs_n_i,
  input  logic             sdi,
  output logic             sdo,
  output logic             sdo_oe
);

  localparam int unsigned CNT_W  = 4;
  localparam int unsigned EDGE_W = $clog2(2 * WORD_W);
  localparam logic [EDGE_W-1:0] LAST_EDGE8 = EDGE_W'(2 * (WORD_W - 1) - 1);
  localparam logic [EDGE_W-1:0] LAST_EDGE9 = EDGE_W'(2 * WORD_W - 1);

  // host-side holding registers
  word_t tx_buf_q, tx_buf_d, rx_buf_q, rx_buf_d;
  logic  tx_empty_q, tx_empty_d, rx_full_q, rx_full_d, rx_err_q, rx_err_d;
  logic  host_en;

  // master sequencing
  logic              m_run_q, m_run_d, sck_q, sck_d;
  logic [EDGE_W-1:0] edge_q, edge_d;
  logic              half, m_start, m_lead, m_trail;
  logic [EDGE_W-1:0] last_edge;

  // slave front end
  logic [2:0] pins_raw, pins_s;
  logic       sck_s, cs_n_s, sdi_s, sel;
  logic       sck_d_q, sel_d_q;
  logic       s_live, s_sel_rise, s_abort, s_edge, s_lead, s_trail;

  // shared shifter controls
  logic             frame_nine, lead, trail, sample, launch, load, bit_in;
  logic             done;
  word_t            rx_word;
  logic [CNT_W-1:0] bit_cnt;

  assign frame_nine = ~cfg_slave & cfg_nine;
  assign last_edge  = frame_nine ? LAST_EDGE9 : LAST_EDGE8;

  spi_sck_gen #(.DIV_W(DIV_W)) u_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (m_run_q & ~cfg_slave),
    .fast_mode (cfg_fast),
    .div_val   (cfg_div),
    .tick      (div_tick),
    .half      (half)
  );

  assign pins_raw = {sck_i, cs_n_i, sdi};

  spi_pin_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b010)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pins_raw),
    .dout  (pins_s)
  );

  assign {sck_s, cs_n_s, sdi_s} = pins_s;
  assign sel = ~cs_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d_q <= 1'b0;
      sel_d_q <= 1'b0;
    end else begin
      sck_d_q <= sck_s;
      sel_d_q <= sel;
    end
  end

  assign s_live     = cfg_slave & sel & sel_d_q;
  assign s_sel_rise = cfg_slave & sel & ~sel_d_q;
  assign s_abort    = cfg_slave & ~sel & sel_d_q;
  assign s_edge     = s_live & (sck_s ^ sck_d_q);
  assign s_lead     = s_edge & (sck_s != cfg_cpol);
  assign s_trail    = s_edge & (sck_s == cfg_cpol);

  assign m_start = ~cfg_slave & ~m_run_q & ~tx_empty_q;
  assign m_lead  = ~cfg_slave & m_run_q & half & ~edge_q[0];
  assign m_trail = ~cfg_slave & m_run_q & half &  edge_q[0];

  assign lead   = cfg_slave ? s_lead  : m_lead;
  assign trail  = cfg_slave ? s_trail : m_trail;
  assign bit_in = cfg_slave ? sdi_s   : sdi;
  assign sample = cfg_cpha ? trail : lead;
  assign launch = cfg_cpha ? lead  : (trail & (bit_cnt != '0));
  assign load   = m_start | s_sel_rise | (cfg_slave & done);

  spi_shift_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_word (tx_buf_q),
    .cpha      (cfg_cpha),
    .lsb_first (cfg_lsb_first),
    .nine      (frame_nine),
    .launch    (launch),
    .sample    (sample),
    .clear     (s_abort),
    .sdi       (bit_in),
    .sdo       (sdo),
    .done      (done),
    .rx_word   (rx_word),
    .bit_cnt   (bit_cnt)
  );

  // master frame sequencer: next state
  always_comb begin
    m_run_d = m_run_q;
    edge_d  = edge_q;
    sck_d   = sck_q;
    if (m_start) begin
      m_run_d = 1'b1;
      edge_d  = '0;
    end else if (m_run_q && half && !cfg_slave) begin
      if (edge_q == last_edge) begin
        m_run_d = 1'b0;
        edge_d  = '0;
      end else begin
        edge_d  = edge_q + 1'b1;
      end
    end
    if (cfg_slave || !m_run_q) sck_d = cfg_cpol;
    else if (half)             sck_d = ~sck_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run_q <= 1'b0;
      edge_q  <= '0;
      sck_q   <= 1'b0;
    end else begin
      m_run_q <= m_run_d;
      edge_q  <= edge_d;
      sck_q   <= sck_d;
    end
  end

  // holding registers: next state
  always_comb begin
    tx_buf_d   = tx_buf_q;
    tx_empty_d = tx_empty_q;
    rx_buf_d   = rx_buf_q;
    rx_full_d  = rx_full_q;
    rx_err_d   = rx_err_q & ~rx_rd;
    if (tx_wr) begin
      tx_buf_d   = tx_data;
      tx_empty_d = 1'b0;
    end else if (load) begin
      tx_empty_d = 1'b1;
    end
    if (done) begin
      if (rx_full_q && !rx_rd) begin
        rx_err_d = 1'b1;
      end else begin
        rx_buf_d  = rx_word;
        rx_full_d = 1'b1;
      end
    end else if (rx_rd) begin
      rx_full_d = 1'b0;
    end
  end

  assign host_en = tx_wr | load | done | rx_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_buf_q   <= '0;
      tx_empty_q <= 1'b1;
      rx_buf_q   <= '0;
      rx_full_q  <= 1'b0;
      rx_err_q   <= 1'b0;
    end else if (host_en) begin
      tx_buf_q   <= tx_buf_d;
      tx_empty_q <= tx_empty_d;
      rx_buf_q   <= rx_buf_d;
      rx_full_q  <= rx_full_d;
      rx_err_q   <= rx_err_d;
    end
  end

  assign rx_data      = rx_buf_q;
  assign irq_tx_empty = tx_empty_q;
  assign irq_rx_full  = rx_full_q;
  assign irq_rx_err   = rx_err_q;
  assign busy         = cfg_slave ? sel : m_run_q;
  assign sck_o        = sck_q;
  assign sdo_oe       = ~cfg_slave | sel;

endmodule

// File: rtl/spi_xfer_engine_chk.sv
module spi_xfer_engine_chk #(
  parameter int unsigned DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_slave,
  input logic             cfg_cpol,
  input logic             cfg_fast,
  input logic             tx_wr,
  input logic             rx_rd,
  input logic [8:0]       rx_data,
  input logic             irq_tx_empty,
  input logic             irq_rx_full,
  input logic             irq_rx_err,
  input logic             busy,
  input logic             sck_o
);

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  a_r3_sck_rest: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !cfg_slave && !busy && $stable(cfg_cpol) && $stable(cfg_slave))
      |-> (sck_o == cfg_cpol));

  a_r5_fast_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !cfg_slave && cfg_fast && busy && $past(busy)
      && $stable(cfg_fast) && $stable(cfg_slave))
      |-> (sck_o != $past(sck_o)));

  a_r6_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && irq_rx_full && !rx_rd) |=> (irq_rx_full && $stable(rx_data)));

  a_r7_err_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $rose(irq_rx_err)) |-> $past(irq_rx_full));

  a_r7_read_clears_err: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && rx_rd) |=> !irq_rx_err);

  a_r10_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && tx_wr) |=> !irq_tx_empty);

endmodule

bind spi_xfer_engine spi_xfer_engine_chk #(.DIV_W(DIV_W)) u_chk (.*);

// File: tb/sim_spi_xfer_engine.sv
`timescale 1ns/1ps
module sim_spi_xfer_engine;

  localparam int DIV_W = 8;
  localparam int H     = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_slave, cfg_cpol, cfg_cpha, cfg_lsb_first, cfg_nine, cfg_fast;
  logic [DIV_W-1:0] cfg_div;
  logic div_tick, tx_wr, rx_rd, sck_i, cs_n_i, sdi;
  logic [8:0] tx_data, rx_data;
  logic irq_tx_empty, irq_rx_full, irq_rx_err, busy, sck_o, sdo, sdo_oe;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  spi_xfer_engine #(.DIV_W(DIV_W), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_slave(cfg_slave), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first), .cfg_nine(cfg_nine),
    .cfg_fast(cfg_fast), .cfg_div(cfg_div), .div_tick(div_tick),
    .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd), .rx_data(rx_data),
    .irq_tx_empty(irq_tx_empty), .irq_rx_full(irq_rx_full), .irq_rx_err(irq_rx_err),
    .busy(busy), .sck_o(sck_o), .sck_i(sck_i), .cs_n_i(cs_n_i), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic bit_at(input logic [8:0] w, input int i, input int n, input bit lsb);
    return lsb ? w[i] : w[n-1-i];
  endfunction

  function automatic logic [8:0] put_bit(input logic [8:0] c, input logic b, input int i,
                                         input int n, input bit lsb);
    logic [8:0] r;
    r = c;
    if (lsb) r[i] = b;
    else     r[n-1-i] = b;
    return r;
  endfunction

  task automatic pulse_read();
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
    @(negedge clk);
  endtask

  // bench plays the remote slave while the design is master
  task automatic run_master(input bit cpol, input bit cpha, input bit lsb, input bit nine,
                            input bit fast, input int div, input logic [8:0] txw,
                            input logic [8:0] slw, input bit do_read);
    int n, k, since, sent, got, bad_half, half_exp, guard;
    logic prev;
    logic [8:0] cap, mask;
    n = nine ? 9 : 8;
    mask = nine ? 9'h1FF : 9'h0FF;
    half_exp = fast ? 1 : div + 1;
    cfg_slave = 1'b0; cfg_cpol = cpol; cfg_cpha = cpha; cfg_lsb_first = lsb;
    cfg_nine = nine; cfg_fast = fast; cfg_div = DIV_W'(div); div_tick = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check_eq("R3 idle clock level", int'(sck_o), int'(cpol));
    sent = 0; got = 0; cap = '0; bad_half = 0; k = 0; since = 0; guard = 0;
    if (!cpha) begin
      sdi = bit_at(slw, 0, n, lsb);
      sent = 1;
    end
    tx_data = txw; tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
    check_eq("R10 write clears empty", int'(irq_tx_empty), 0);
    prev = sck_o;
    while (k < 2 * n && guard < 4000) begin
      @(negedge clk);
      guard++;
      since++;
      if (sck_o != prev) begin
        k++;
        prev = sck_o;
        if (k > 1 && since != half_exp) bad_half++;
        since = 0;
        if ((k % 2 == 1) ^ cpha) begin
          cap = put_bit(cap, sdo, got, n, lsb);
          got++;
        end else if (sent < n) begin
          sdi = bit_at(slw, sent, n, lsb);
          sent++;
        end
      end
    end
    check_eq("R2 edge count", k, 2 * n);
    check_eq("R5 half period", bad_half, 0);
    check_eq("R4 R3 word on sdo", int'(cap), int'(txw & mask));
    repeat (4) @(negedge clk);
    check_eq("R2 busy after frame", int'(busy), 0);
    check_eq("R2 tx empty after load", int'(irq_tx_empty), 1);
    check_eq("R3 clock back at rest", int'(sck_o), int'(cpol));
    check_eq("R11 master oe", int'(sdo_oe), 1);
    if (do_read) begin
      check_eq("R6 rx full", int'(irq_rx_full), 1);
      check_eq("R4 R6 received word", int'(rx_data), int'(slw & mask));
      pulse_read();
      check_eq("R6 read clears full", int'(irq_rx_full), 0);
    end
  endtask

  // bench plays the remote master while the design is slave
  task automatic slave_frame(input int nbits, input logic [8:0] mw, input bit cpol,
                             input bit cpha, input bit lsb, output logic [8:0] cap);
    cap = '0;
    if (!cpha) sdi = bit_at(mw, 0, 8, lsb);
    cs_n_i = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      if (!cpha) begin
        cap = put_bit(cap, sdo, i, 8, lsb);
        sck_i = ~cpol;
        repeat (H) @(negedge clk);
        sck_i = cpol;
        if (i < 7) sdi = bit_at(mw, i + 1, 8, lsb);
        repeat (H) @(negedge clk);
      end else begin
        sck_i = ~cpol;
        sdi = bit_at(mw, i, 8, lsb);
        repeat (H) @(negedge clk);
        cap = put_bit(cap, sdo, i, 8, lsb);
        sck_i = cpol;
        repeat (H) @(negedge clk);
      end
    end
  endtask

  task automatic run_slave(input bit cpol, input bit cpha, input bit lsb,
                           input logic [8:0] txw, input logic [8:0] mw, input bit abort);
    logic [8:0] cap;
    cfg_slave = 1'b1; cfg_cpol = cpol; cfg_cpha = cpha; cfg_lsb_first = lsb;
    cfg_nine = 1'b1; cfg_fast = 1'b0;
    sck_i = cpol; cs_n_i = 1'b1;
    repeat (H) @(negedge clk);
    check_eq("R11 slave oe when idle", int'(sdo_oe), 0);
    tx_data = txw; tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
    if (abort) begin
      slave_frame(3, ~mw, cpol, cpha, lsb, cap);
      cs_n_i = 1'b1;
      repeat (2 * H) @(negedge clk);
      check_eq("R9 aborted frame not stored", int'(irq_rx_full), 0);
    end
    slave_frame(8, mw, cpol, cpha, lsb, cap);
    check_eq("R11 slave oe when selected", int'(sdo_oe), 1);
    check_eq("R8 slave sent byte", int'(cap), int'(txw & 9'h0FF));
    check_eq("R8 slave rx full", int'(irq_rx_full), 1);
    check_eq("R8 R9 slave received byte", int'(rx_data), int'(mw & 9'h0FF));
    cs_n_i = 1'b1;
    repeat (H) @(negedge clk);
    pulse_read();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_slave = 1'b0; cfg_cpol = 1'b1; cfg_cpha = 1'b0; cfg_lsb_first = 1'b0;
    cfg_nine = 1'b0; cfg_fast = 1'b1; cfg_div = '0; div_tick = 1'b0;
    tx_wr = 1'b0; tx_data = '0; rx_rd = 1'b0; sck_i = 1'b0; cs_n_i = 1'b1; sdi = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check_eq("R1 tx empty", int'(irq_tx_empty), 1);
    check_eq("R1 rx full", int'(irq_rx_full), 0);
    check_eq("R1 rx err", int'(irq_rx_err), 0);
    check_eq("R1 busy", int'(busy), 0);
    check_eq("R1 clock rest", int'(sck_o), 1);

    // full sweep of master options
    for (int idx = 0; idx < 32; idx++) begin
      run_master(idx[0], idx[1], idx[2], idx[3], idx[4], 2,
                 9'((idx * 37 + 9'h05A) & 9'h1FF), 9'((9'h1A3 ^ (idx * 29)) & 9'h1FF), 1'b1);
    end
    // other divider settings
    run_master(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 9'h0C3, 9'h03C, 1'b1);
    run_master(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4, 9'h155, 9'h0AA, 1'b1);

    // overrun: two frames, no read between them
    run_master(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 0, 9'h012, 9'h0E7, 1'b0);
    check_eq("R6 full after first frame", int'(irq_rx_full), 1);
    check_eq("R7 no error yet", int'(irq_rx_err), 0);
    run_master(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 0, 9'h034, 9'h05B, 1'b0);
    check_eq("R7 overrun flagged", int'(irq_rx_err), 1);
    check_eq("R7 unread word kept", int'(rx_data), 9'h0E7);
    pulse_read();
    check_eq("R7 read clears error", int'(irq_rx_err), 0);
    check_eq("R6 read clears full", int'(irq_rx_full), 0);

    // slave sweep, half with an aborted frame first
    for (int idx = 0; idx < 8; idx++) begin
      run_slave(idx[0], idx[1], idx[2], 9'((idx * 53 + 9'h1C6) & 9'h1FF),
                9'((idx * 71 + 9'h02D) & 9'h0FF), idx[0] ^ idx[1]);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule